// File: doc/BRIEF.md
# Load/Store Address Alignment Unit

This unit sits between a 32-bit core's register file and its memory bus. For each load or store it forms the effective address from the operand values the core supplies. Three addressing modes are available: plain register-indirect, a base register plus a second register, and a base register plus a scaled 5-bit immediate. The base is either of the two base registers the core presents. The unit then decides how to align the access and sends a single registered request to the bus.

Alignment depends on where the final address lands. Inside the local RAM window (0xF03000 to 0xF03FFF inclusive), long accesses drop their two low bits, word accesses drop bit 0 and become long-width local transfers, and phrase (64-bit) accesses drop their three low bits. Outside the window the address goes out unchanged, with one exception: a register-indirect long load is always long-aligned.

A phrase access is split into two back-to-back long transfers, at the address and at the address plus 4. The upper word of a phrase moves through a hidden high-data register, which the core can also write directly. While the second transfer is pending the unit raises `busy`, and any request offered in that cycle is dropped.

Top module: `ldst_align`

## Requirements
- R1: After reset, `bus_req`, `busy` and `ld_valid` are 0 and `hi_data` is 0.
- R2: The effective address is formed by mode. Mode 0 gives `idx_val`. Mode 1 gives base + `idx_val`. Mode 2 gives base + 4×`imm5`, where an `imm5` of 0 counts as 32. The base is `r14_val` when `base_sel`=0 and `r15_val` when `base_sel`=1.
- R3: The window test uses the final effective address, so a base inside the window with an offset that leaves it counts as outside, and the reverse also holds. Both 0xF03000 and 0xF03FFF are inside.
- R4: Long stores, and long loads in modes 1 and 2, go out as `bus_size`=1 (long). The address has bits [1:0] cleared inside the window and is unchanged outside it.
- R5: A long load in mode 0 always clears address bits [1:0], whatever the address.
- R6: A word access inside the window goes out as `bus_size`=1 with address bit 0 cleared. A word store drives `{16'h0, st_data[15:0]}`, and a word load returns `bus_rdata[15:0]` zero-extended.
- R7: A word access outside the window goes out as `bus_size`=0 (16-bit) at the unchanged address. Store data and load results are 16 bits zero-extended, as in R6.
- R8: A request is taken at a clock edge where `req_valid`=1 and `busy`=0. `bus_req` is high for the cycle after that edge, and `bus_we`=1 marks a write. `bus_rdata` is sampled while `bus_req` is high. `ld_valid` and `ld_data` appear in the cycle after the final read transfer.
- R9: A phrase access (op 4 load, op 5 store) makes two consecutive long transfers, at A and then at A+4. A is the effective address with bits [2:0] cleared inside the window and unchanged outside it. `busy` is high exactly during the first transfer.
- R10: A phrase store writes `hi_data` in the first transfer and `st_data` in the second.
- R11: A phrase load puts the first transfer's read data into `hi_data` and returns the second transfer's read data on `ld_data`.
- R12: A request offered while `busy`=1 is dropped and produces no bus transfer.
- R13: When `hi_wr_en`=1 at a clock edge, `hi_data` takes `hi_wr_data` from the next cycle on.

Op encoding for `op_kind`: 0 long load, 1 long store, 2 word load, 3 word store, 4 phrase load, 5 phrase store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered this cycle |
| op_kind | input | 3 | Operation class (see encoding) |
| addr_mode | input | 2 | 0 indirect, 1 base+register, 2 base+immediate |
| base_sel | input | 1 | Base register select |
| r14_val | input | 32 | First base register value |
| r15_val | input | 32 | Second base register value |
| idx_val | input | 32 | Indirect/index register value |
| imm5 | input | 5 | Immediate field, scaled by 4 |
| st_data | input | 32 | Store data |
| hi_wr_en | input | 1 | Direct write of the high-data register |
| hi_wr_data | input | 32 | Value for the direct write |
| bus_rdata | input | 32 | Read data, valid while `bus_req` is high |
| busy | output | 1 | Second phrase transfer pending; core must stall |
| bus_req | output | 1 | Bus transfer this cycle |
| bus_we | output | 1 | 1 write, 0 read |
| bus_size | output | 1 | 1 long, 0 word |
| bus_addr | output | 32 | Transfer address |
| bus_wdata | output | 32 | Write data |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Load result |
| hi_data | output | 32 | High-data register |

## Verification
The bench probes the window edges and the base-versus-final-address cases. If the window test were applied to the base register instead of the final address, a base just below the window with an offset into it would come out misaligned, and a base near the top of the window with an offset past it would be wrongly masked. An immediate field of zero is tested, since a unit that took it literally would send the base address itself. For phrases, the bench checks the second address (A+4 after 8-byte alignment inside the window and no alignment outside), the order of the two data words, and the capture of the first read beat into the high-data register. It also offers a request during `busy`; a unit that accepted it would place a third transfer on the bus.

// File: rtl/ldst_align_pkg.sv
package ldst_align_pkg;
    typedef enum logic [2:0] {
        OP_LD_L = 3'd0,
        OP_ST_L = 3'd1,
        OP_LD_W = 3'd2,
        OP_ST_W = 3'd3,
        OP_LD_P = 3'd4,
        OP_ST_P = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        AM_IND  = 2'd0,
        AM_BREG = 2'd1,
        AM_BIMM = 2'd2
    } am_e;

    localparam logic SZ_WORD = 1'b0;
    localparam logic SZ_LONG = 1'b1;
endpackage

// File: rtl/ldst_ea_calc.sv
module ldst_ea_calc #(
    parameter int          AW     = 32,
    parameter int          IMM_W  = 5,
    parameter logic [AW-1:0] WIN_LO = 32'h00F0_3000,
    parameter logic [AW-1:0] WIN_HI = 32'h00F0_3FFF
) (
    input  logic [1:0]       mode,
    input  logic             base_sel,
    input  logic [AW-1:0]    r14_val,
    input  logic [AW-1:0]    r15_val,
    input  logic [AW-1:0]    idx_val,
    input  logic [IMM_W-1:0] imm,
    output logic [AW-1:0]    ea,
    output logic             in_win
);
    import ldst_align_pkg::*;

    localparam logic [IMM_W:0] IMM_ZERO_AS = (IMM_W+1)'(1) << IMM_W;

    logic [AW-1:0] base;
    logic [IMM_W:0] imm_ext;
    logic [AW-1:0] imm_off;

    always_comb begin
        base    = base_sel ? r15_val : r14_val;
        imm_ext = (imm == '0) ? IMM_ZERO_AS : {1'b0, imm};
        imm_off = AW'(imm_ext) << 2;
        unique case (am_e'(mode))
            AM_BREG: ea = base + idx_val;
            AM_BIMM: ea = base + imm_off;
            default: ea = idx_val;
        endcase
        in_win = (ea >= WIN_LO) && (ea <= WIN_HI);
    end
endmodule

// File: rtl/ldst_fmt.sv
module ldst_fmt #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic [2:0]    op,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] ea,
    input  logic          in_win,
    input  logic [DW-1:0] st_data,
    input  logic [DW-1:0] hi_q,
    output logic [AW-1:0] addr0,
    output logic          size,
    output logic          we,
    output logic [DW-1:0] wdata0,
    output logic          phrase,
    output logic          trunc
);
    import ldst_align_pkg::*;

    localparam int HALF = DW / 2;

    logic [DW-1:0] half_data;

    always_comb begin
        half_data = {{(DW-HALF){1'b0}}, st_data[HALF-1:0]};
        addr0  = ea;
        size   = SZ_LONG;
        we     = 1'b0;
        wdata0 = st_data;
        phrase = 1'b0;
        trunc  = 1'b0;
        unique case (op_e'(op))
            OP_LD_L: begin
                if (in_win || am_e'(mode) == AM_IND)
                    addr0 = {ea[AW-1:2], 2'b00};
            end
            OP_ST_L: begin
                we = 1'b1;
                if (in_win) addr0 = {ea[AW-1:2], 2'b00};
            end
            OP_LD_W, OP_ST_W: begin
                we     = (op_e'(op) == OP_ST_W);
                trunc  = 1'b1;
                wdata0 = half_data;
                if (in_win) addr0 = {ea[AW-1:1], 1'b0};
                else        size  = SZ_WORD;
            end
            OP_LD_P, OP_ST_P: begin
                we     = (op_e'(op) == OP_ST_P);
                phrase = 1'b1;
                wdata0 = hi_q;
                if (in_win) addr0 = {ea[AW-1:3], 3'b000};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ldst_align.sv
module ldst_align #(
    parameter int          AW     = 32,
    parameter int          DW     = 32,
    parameter int          IMM_W  = 5,
    parameter logic [31:0] WIN_LO = 32'h00F0_3000,
    parameter logic [31:0] WIN_HI = 32'h00F0_3FFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       op_kind,
    input  logic [1:0]       addr_mode,
    input  logic             base_sel,
    input  logic [AW-1:0]    r14_val,
    input  logic [AW-1:0]    r15_val,
    input  logic [AW-1:0]    idx_val,
    input  logic [IMM_W-1:0] imm5,
    input  logic [DW-1:0]    st_data,
    input  logic             hi_wr_en,
    input  logic [DW-1:0]    hi_wr_data,
    input  logic [DW-1:0]    bus_rdata,
    output logic             busy,
    output logic             bus_req,
    output logic             bus_we,
    output logic             bus_size,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_wdata,
    output logic             ld_valid,
    output logic [DW-1:0]    ld_data,
    output logic [DW-1:0]    hi_data
);
    import ldst_align_pkg::*;

    localparam int HALF = DW / 2;
    localparam logic [AW-1:0] BEAT_STEP = AW'(DW / 8);

    typedef struct packed {
        logic          req;
        logic          we;
        logic          size;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          to_hi;
        logic          trunc;
        logic          pend;
        logic          pend_we;
        logic [AW-1:0] pend_addr;
        logic [DW-1:0] pend_wdata;
        logic          ld_v;
        logic [DW-1:0] ld;
        logic [DW-1:0] hi;
    } st_t;

    st_t s_d, s_q;

    logic [AW-1:0] ea;
    logic          in_win;
    logic [AW-1:0] f_addr;
    logic          f_size, f_we, f_phrase, f_trunc;
    logic [DW-1:0] f_wdata;

    ldst_ea_calc #(.AW(AW), .IMM_W(IMM_W), .WIN_LO(AW'(WIN_LO)), .WIN_HI(AW'(WIN_HI))) u_ea (
        .mode(addr_mode), .base_sel(base_sel), .r14_val(r14_val), .r15_val(r15_val),
        .idx_val(idx_val), .imm(imm5), .ea(ea), .in_win(in_win)
    );

    ldst_fmt #(.AW(AW), .DW(DW)) u_fmt (
        .op(op_kind), .mode(addr_mode), .ea(ea), .in_win(in_win), .st_data(st_data),
        .hi_q(s_q.hi), .addr0(f_addr), .size(f_size), .we(f_we), .wdata0(f_wdata),
        .phrase(f_phrase), .trunc(f_trunc)
    );

    always_comb begin
        s_d      = s_q;
        s_d.req  = 1'b0;
        s_d.ld_v = 1'b0;
        if (hi_wr_en) s_d.hi = hi_wr_data;
        // read data returned in the cycle the request is on the bus
        if (s_q.req && !s_q.we) begin
            if (s_q.to_hi) begin
                s_d.hi = bus_rdata;
            end else begin
                s_d.ld_v = 1'b1;
                s_d.ld   = s_q.trunc ? {{(DW-HALF){1'b0}}, bus_rdata[HALF-1:0]} : bus_rdata;
            end
        end
        if (s_q.pend) begin
            s_d.req   = 1'b1;
            s_d.we    = s_q.pend_we;
            s_d.size  = SZ_LONG;
            s_d.addr  = s_q.pend_addr;
            s_d.wdata = s_q.pend_wdata;
            s_d.to_hi = 1'b0;
            s_d.trunc = 1'b0;
            s_d.pend  = 1'b0;
        end else if (req_valid) begin
            s_d.req        = 1'b1;
            s_d.we         = f_we;
            s_d.size       = f_size;
            s_d.addr       = f_addr;
            s_d.wdata      = f_wdata;
            s_d.trunc      = f_trunc;
            s_d.to_hi      = f_phrase && !f_we;
            s_d.pend       = f_phrase;
            s_d.pend_we    = f_we;
            s_d.pend_addr  = f_addr + BEAT_STEP;
            s_d.pend_wdata = st_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.pend;
    assign bus_req   = s_q.req;
    assign bus_we    = s_q.we;
    assign bus_size  = s_q.size;
    assign bus_addr  = s_q.addr;
    assign bus_wdata = s_q.wdata;
    assign ld_valid  = s_q.ld_v;
    assign ld_data   = s_q.ld;
    assign hi_data   = s_q.hi;
endmodule

// File: rtl/ldst_align_chk.sv
module ldst_align_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        bus_req,
    input logic        bus_we,
    input logic        bus_size,
    input logic [31:0] bus_addr,
    input logic        ld_valid
);
    // R8
    req_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($past(req_valid) || $past(busy)));
    // R9
    busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
    // R9
    busy_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bus_req && bus_size));
    // R9
    second_beat_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (bus_req && bus_addr == $past(bus_addr) + 32'd4));
    // R8
    load_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> $past(bus_req && !bus_we));
    // R7
    word_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_size) |-> (bus_addr < 32'h00F0_3000 || bus_addr > 32'h00F0_3FFF));
endmodule

bind ldst_align ldst_align_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .bus_req(bus_req),
    .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr), .ld_valid(ld_valid)
);

// File: tb/tb_ldst_align.sv
module tb_ldst_align;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  op_kind = '0;
    logic [1:0]  addr_mode = '0;
    logic        base_sel = 1'b0;
    logic [31:0] r14_val = '0, r15_val = '0, idx_val = '0;
    logic [4:0]  imm5 = '0;
    logic [31:0] st_data = '0;
    logic        hi_wr_en = 1'b0;
    logic [31:0] hi_wr_data = '0;
    logic [31:0] bus_rdata = '0;
    logic        busy, bus_req, bus_we, bus_size, ld_valid;
    logic [31:0] bus_addr, bus_wdata, ld_data, hi_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ldst_align dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op_kind(op_kind),
        .addr_mode(addr_mode), .base_sel(base_sel), .r14_val(r14_val), .r15_val(r15_val),
        .idx_val(idx_val), .imm5(imm5), .st_data(st_data), .hi_wr_en(hi_wr_en),
        .hi_wr_data(hi_wr_data), .bus_rdata(bus_rdata), .busy(busy), .bus_req(bus_req),
        .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .ld_valid(ld_valid), .ld_data(ld_data), .hi_data(hi_data)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  md;
        logic        bs;
        logic [31:0] r14;
        logic [31:0] r15;
        logic [31:0] idx;
        logic [4:0]  imm;
        logic [31:0] st;
        logic [31:0] rd;
        logic [31:0] ea;
        logic        sz;
        logic [31:0] wd;
        logic [31:0] ld;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        // R5: indirect long load inside window
        '{3'd0, 2'd0, 1'b0, 32'h0, 32'h0, 32'h00F03002, 5'd0, 32'h0, 32'h11223344, 32'h00F03000, 1'b1, 32'h0, 32'h11223344},
        // R5: indirect long load outside window still aligned
        '{3'd0, 2'd0, 1'b0, 32'h0, 32'h0, 32'h00001003, 5'd0, 32'h0, 32'h55667788, 32'h00001000, 1'b1, 32'h0, 32'h55667788},
        // R4 R2: base+reg inside window
        '{3'd0, 2'd1, 1'b0, 32'h00F03000, 32'h0, 32'h3, 5'd0, 32'h0, 32'h9ABCDEF0, 32'h00F03000, 1'b1, 32'h0, 32'h9ABCDEF0},
        // R4 R2: base+reg on second base, outside, unmodified
        '{3'd0, 2'd1, 1'b1, 32'h0, 32'h00002000, 32'h2, 5'd0, 32'h0, 32'h0BADF00D, 32'h00002002, 1'b1, 32'h0, 32'h0BADF00D},
        // R3 R2: base outside, imm 0 means 32, final address inside
        '{3'd1, 2'd2, 1'b0, 32'h00F02FF1, 32'h0, 32'h0, 5'd0, 32'hA5A5A5A5, 32'h0, 32'h00F03070, 1'b1, 32'hA5A5A5A5, 32'h0},
        // R3: base inside, final address outside, unmodified
        '{3'd1, 2'd2, 1'b1, 32'h0, 32'h00F03FFD, 32'h0, 5'd1, 32'h12345678, 32'h0, 32'h00F04001, 1'b1, 32'h12345678, 32'h0},
        // R4 R3: top edge of window
        '{3'd1, 2'd0, 1'b0, 32'h0, 32'h0, 32'h00F03FFF, 5'd0, 32'h87654321, 32'h0, 32'h00F03FFC, 1'b1, 32'h87654321, 32'h0},
        // R4 R3: just below window, unmodified
        '{3'd1, 2'd0, 1'b0, 32'h0, 32'h0, 32'h00F02FFF, 5'd0, 32'h0F0F0F0F, 32'h0, 32'h00F02FFF, 1'b1, 32'h0F0F0F0F, 32'h0},
        // R6: word load inside window
        '{3'd2, 2'd0, 1'b0, 32'h0, 32'h0, 32'h00F03011, 5'd0, 32'h0, 32'hAABBCCDD, 32'h00F03010, 1'b1, 32'h0, 32'h0000CCDD},
        // R7: word load outside window
        '{3'd2, 2'd0, 1'b0, 32'h0, 32'h0, 32'h00400003, 5'd0, 32'h0, 32'h1234FEDC, 32'h00400003, 1'b0, 32'h0, 32'h0000FEDC},
        // R6: word store inside window
        '{3'd3, 2'd1, 1'b0, 32'h00F03000, 32'h0, 32'h5, 5'd0, 32'hDEADBEEF, 32'h0, 32'h00F03004, 1'b1, 32'h0000BEEF, 32'h0},
        // R7 R2: word store outside, imm 31
        '{3'd3, 2'd2, 1'b1, 32'h0, 32'h00000100, 32'h0, 5'd31, 32'hDEADBEEF, 32'h0, 32'h0000017C, 1'b0, 32'h0000BEEF, 32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive_req(input logic [2:0] op, input logic [1:0] md, input logic bs,
                             input logic [31:0] a14, input logic [31:0] a15,
                             input logic [31:0] ix, input logic [4:0] im, input logic [31:0] sd);
        req_valid = 1'b1; op_kind = op; addr_mode = md; base_sel = bs;
        r14_val = a14; r15_val = a15; idx_val = ix; imm5 = im; st_data = sd;
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk("R1 bus_req", {31'b0, bus_req}, 32'h0);
        chk("R1 busy", {31'b0, busy}, 32'h0);
        chk("R1 ld_valid", {31'b0, ld_valid}, 32'h0);
        chk("R1 hi_data", hi_data, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive_req(VEC[i].op, VEC[i].md, VEC[i].bs, VEC[i].r14, VEC[i].r15,
                      VEC[i].idx, VEC[i].imm, VEC[i].st);
            bus_rdata = VEC[i].rd;
            @(posedge clk); @(negedge clk);
            req_valid = 1'b0;
            // R8
            chk($sformatf("R8 req v%0d", i), {31'b0, bus_req}, 32'h1);
            chk($sformatf("R2/R3 addr v%0d", i), bus_addr, VEC[i].ea);
            chk($sformatf("R4/R6/R7 size v%0d", i), {31'b0, bus_size}, {31'b0, VEC[i].sz});
            chk($sformatf("R8 we v%0d", i), {31'b0, bus_we}, {31'b0, VEC[i].op[0]});
            if (VEC[i].op[0]) chk($sformatf("R6/R7 wdata v%0d", i), bus_wdata, VEC[i].wd);
            @(posedge clk); @(negedge clk);
            chk($sformatf("R8 ld_valid v%0d", i), {31'b0, ld_valid}, {31'b0, !VEC[i].op[0]});
            if (!VEC[i].op[0]) chk($sformatf("R6/R7 ld_data v%0d", i), ld_data, VEC[i].ld);
        end

        // R13: direct high-data write
        hi_wr_en = 1'b1; hi_wr_data = 32'hCAFEF00D;
        @(posedge clk); @(negedge clk);
        hi_wr_en = 1'b0;
        chk("R13 hi_data", hi_data, 32'hCAFEF00D);

        // R9 R10 R12: phrase store inside window, extra request during busy
        drive_req(3'd5, 2'd0, 1'b0, 32'h0, 32'h0, 32'h00F0300C, 5'd0, 32'h55AA55AA);
        @(posedge clk); @(negedge clk);
        chk("R9 busy beat0", {31'b0, busy}, 32'h1);
        chk("R9 addr beat0", bus_addr, 32'h00F03008);
        chk("R10 wdata beat0", bus_wdata, 32'hCAFEF00D);
        drive_req(3'd0, 2'd0, 1'b0, 32'h0, 32'h0, 32'h00000040, 5'd0, 32'h0);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy beat1", {31'b0, busy}, 32'h0);
        chk("R9 addr beat1", bus_addr, 32'h00F0300C);
        chk("R10 wdata beat1", bus_wdata, 32'h55AA55AA);
        chk("R9 we beat1", {31'b0, bus_we}, 32'h1);
        @(posedge clk); @(negedge clk);
        chk("R12 no extra transfer", {31'b0, bus_req}, 32'h0);

        // R9 R11: phrase load outside window
        drive_req(3'd4, 2'd0, 1'b0, 32'h0, 32'h0, 32'h00000102, 5'd0, 32'h0);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R9 out addr beat0", bus_addr, 32'h00000102);
        bus_rdata = 32'h01010101;
        @(posedge clk); @(negedge clk);
        chk("R11 hi capture", hi_data, 32'h01010101);
        chk("R9 out addr beat1", bus_addr, 32'h00000106);
        chk("R11 no early ld_valid", {31'b0, ld_valid}, 32'h0);
        bus_rdata = 32'h02020202;
        @(posedge clk); @(negedge clk);
        chk("R11 ld_valid", {31'b0, ld_valid}, 32'h1);
        chk("R11 ld_data", ld_data, 32'h02020202);

        // R9: phrase load at window top edge, 8-byte aligned
        drive_req(3'd4, 2'd1, 1'b1, 32'h0, 32'h00F03FF0, 32'h0000000F, 5'd0, 32'h0);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R9 in addr beat0", bus_addr, 32'h00F03FF8);
        @(posedge clk); @(negedge clk);
        chk("R9 in addr beat1", bus_addr, 32'h00F03FFC);
        @(posedge clk); @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule